// File: doc/BRIEF.md
# Warp Issue Scheduler with Memory-Stall Skipping

This block decides, every clock, which resident warps of one compute unit may issue an instruction. It keeps a table of warp entries. Each entry is either free or resident, and a resident warp is either ready or waiting. Several issue slots work side by side. Each slot grants at most one ready warp per cycle, and no warp is granted by two slots in the same cycle.

When the issue stage sees that the instruction it just granted is a long-latency memory access, it raises that slot's stall request in the same cycle. The granted warp then turns to waiting, and every slot skips it. When the memory system returns data tagged with that warp's ID, the warp becomes ready again and takes part in selection. Warps are admitted by an allocate port and removed by a retire port.

Warps are split statically across slots by ID modulo the slot count. Each slot rotates fairly among its own ready warps. A slot with nothing ready drives its grant-valid low.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is resident and every grant-valid output is low.
- R2: An allocate of a free warp makes it resident and ready from the next cycle. An allocate of a warp that is already resident has no effect, so a waiting warp stays waiting.
- R3: Slot s grants only warps whose ID modulo NUM_SLOTS equals s. Every granted warp is resident and not waiting. Slot s places its warp ID in grant_wid_o bits [s*WID_W +: WID_W].
- R4: Within a slot, the grant goes to the first ready warp in ascending local index (ID divided by NUM_SLOTS), searching from the index after the last warp that slot granted and wrapping. After reset the search starts at local index 0.
- R5: A slot with no ready warp drives its grant-valid low.
- R6: A stall request on a slot whose grant is valid marks the granted warp waiting. It is not granted from the next cycle until its memory return. A stall request on a slot without a grant has no effect.
- R7: A memory return for a resident waiting warp makes it ready from the next cycle.
- R8: A memory return and a new stall for the same warp in the same cycle leave that warp waiting.
- R9: A retire clears the warp's entry from the next cycle. The same ID can be allocated in the cycle right after the retire and comes back ready.
- R10: A memory return for a warp that is not resident has no effect; the warp is not granted.
- R11: No two slots grant the same warp ID in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Allocate request |
| alloc_wid_i | input | WID_W | Warp ID to allocate |
| retire_valid_i | input | 1 | Retire request |
| retire_wid_i | input | WID_W | Warp ID to retire |
| stall_i | input | NUM_SLOTS | Per-slot stall request for this cycle's granted warp |
| mem_ret_valid_i | input | 1 | Memory return strobe |
| mem_ret_wid_i | input | WID_W | Warp ID carried by the memory return |
| grant_valid_o | output | NUM_SLOTS | Per-slot grant valid |
| grant_wid_o | output | NUM_SLOTS*WID_W | Per-slot granted warp ID, slot s at [s*WID_W +: WID_W] |

## Verification
Some properties are checked on every cycle against the state table:
- each grant lands on a ready warp in its own slot's partition;
- an idle slot truly has nothing ready;
- a stalled warp is never granted in the next cycle, and a stall that coincides with a return still blocks;
- returns, allocations and retires change the entry by the following cycle;
- no two slots grant the same ID.

Only the bench's reference model can show the exact round-robin order within a slot, the fact that allocating an already-resident warp has no effect, and the behaviour of long mixed runs. It does this by predicting each slot's grant cycle by cycle.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  parameter int unsigned DEF_NUM_WARPS = 64;
  parameter int unsigned DEF_NUM_SLOTS = 4;

  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/warp_state_table.sv
module warp_state_table
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = DEF_NUM_WARPS,
  parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
  localparam int unsigned WID_W = idx_bits(NUM_WARPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_valid_i,
  input  logic [WID_W-1:0]           alloc_wid_i,
  input  logic                       retire_valid_i,
  input  logic [WID_W-1:0]           retire_wid_i,
  input  logic [NUM_SLOTS-1:0]       stall_valid_i,
  input  logic [NUM_SLOTS*WID_W-1:0] stall_wid_i,
  input  logic                       mem_ret_valid_i,
  input  logic [WID_W-1:0]           mem_ret_wid_i,
  output logic [NUM_WARPS-1:0]       resident_o,
  output logic [NUM_WARPS-1:0]       ready_o
);
  logic [NUM_WARPS-1:0] res_q, res_d;
  logic [NUM_WARPS-1:0] wait_q, wait_d;

  // Order sets precedence: return < stall < allocate < retire.
  always_comb begin
    res_d  = res_q;
    wait_d = wait_q;
    if (mem_ret_valid_i) wait_d[mem_ret_wid_i] = 1'b0;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      if (stall_valid_i[s]) wait_d[stall_wid_i[s*WID_W +: WID_W]] = 1'b1;
    end
    if (alloc_valid_i && !res_q[alloc_wid_i]) begin
      res_d[alloc_wid_i]  = 1'b1;
      wait_d[alloc_wid_i] = 1'b0;
    end
    if (retire_valid_i) begin
      res_d[retire_wid_i]  = 1'b0;
      wait_d[retire_wid_i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      wait_q <= '0;
    end else begin
      res_q  <= res_d;
      wait_q <= wait_d;
    end
  end

  assign resident_o = res_q;
  assign ready_o    = res_q & ~wait_q;
endmodule

// File: rtl/rr_picker.sv
module rr_picker
  import warp_sched_pkg::*;
#(
  parameter int unsigned N = 16,
  localparam int unsigned LW = idx_bits(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          gnt_valid_o,
  output logic [LW-1:0] gnt_idx_o
);
  logic [LW-1:0] last_q;

  // Search starts one past the last grant and wraps.
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = 1; i <= int'(N); i++) begin
      if (!gnt_valid_o && req_i[(int'(last_q) + i) % int'(N)]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = LW'((int'(last_q) + i) % int'(N));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_q <= LW'(N - 1);
    else if (gnt_valid_o) last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = DEF_NUM_WARPS,
  parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
  localparam int unsigned WID_W = idx_bits(NUM_WARPS),
  localparam int unsigned PER_SLOT = NUM_WARPS / NUM_SLOTS,
  localparam int unsigned LW = idx_bits(PER_SLOT)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_valid_i,
  input  logic [WID_W-1:0]           alloc_wid_i,
  input  logic                       retire_valid_i,
  input  logic [WID_W-1:0]           retire_wid_i,
  input  logic [NUM_SLOTS-1:0]       stall_i,
  input  logic                       mem_ret_valid_i,
  input  logic [WID_W-1:0]           mem_ret_wid_i,
  output logic [NUM_SLOTS-1:0]       grant_valid_o,
  output logic [NUM_SLOTS*WID_W-1:0] grant_wid_o
);
  logic [NUM_WARPS-1:0] warp_ready;
  logic [NUM_WARPS-1:0] warp_resident;
  logic [NUM_SLOTS-1:0] stall_valid;

  assign stall_valid = grant_valid_o & stall_i;

  warp_state_table #(
    .NUM_WARPS(NUM_WARPS),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_table (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alloc_valid_i  (alloc_valid_i),
    .alloc_wid_i    (alloc_wid_i),
    .retire_valid_i (retire_valid_i),
    .retire_wid_i   (retire_wid_i),
    .stall_valid_i  (stall_valid),
    .stall_wid_i    (grant_wid_o),
    .mem_ret_valid_i(mem_ret_valid_i),
    .mem_ret_wid_i  (mem_ret_wid_i),
    .resident_o     (warp_resident),
    .ready_o        (warp_ready)
  );

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot
    logic [PER_SLOT-1:0] req;
    logic [LW-1:0]       idx;

    // Slot s owns warps s, s+NUM_SLOTS, s+2*NUM_SLOTS, ...
    always_comb begin
      for (int l = 0; l < int'(PER_SLOT); l++) req[l] = warp_ready[l*int'(NUM_SLOTS) + s];
    end

    rr_picker #(.N(PER_SLOT)) u_pick (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req),
      .gnt_valid_o(grant_valid_o[s]),
      .gnt_idx_o  (idx)
    );

    assign grant_wid_o[s*WID_W +: WID_W] = WID_W'(int'(idx) * int'(NUM_SLOTS) + s);
  end
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = DEF_NUM_WARPS,
  parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
  localparam int unsigned WID_W = idx_bits(NUM_WARPS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       alloc_valid_i,
  input logic [WID_W-1:0]           alloc_wid_i,
  input logic                       retire_valid_i,
  input logic [WID_W-1:0]           retire_wid_i,
  input logic [NUM_SLOTS-1:0]       stall_i,
  input logic                       mem_ret_valid_i,
  input logic [WID_W-1:0]           mem_ret_wid_i,
  input logic [NUM_SLOTS-1:0]       grant_valid_o,
  input logic [NUM_SLOTS*WID_W-1:0] grant_wid_o,
  input logic [NUM_WARPS-1:0]       warp_ready,
  input logic [NUM_WARPS-1:0]       warp_resident
);
  logic [WID_W-1:0]     gw [NUM_SLOTS];
  logic                 mem_stalled;
  logic [NUM_SLOTS-1:0] slot_any;

  always_comb begin
    mem_stalled = 1'b0;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      gw[s] = grant_wid_o[s*WID_W +: WID_W];
      if (grant_valid_o[s] && stall_i[s] && gw[s] == mem_ret_wid_i) mem_stalled = 1'b1;
      slot_any[s] = 1'b0;
      for (int w = 0; w < int'(NUM_WARPS); w++) begin
        if ((w % int'(NUM_SLOTS)) == s && warp_ready[w]) slot_any[s] = 1'b1;
      end
    end
  end

  // R2
  alloc_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !warp_resident[alloc_wid_i] &&
     !(retire_valid_i && retire_wid_i == alloc_wid_i)) |=> warp_ready[$past(alloc_wid_i)]);

  // R7
  return_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ret_valid_i && warp_resident[mem_ret_wid_i] && !mem_stalled &&
     !(retire_valid_i && retire_wid_i == mem_ret_wid_i)) |=> warp_ready[$past(mem_ret_wid_i)]);

  // R8
  return_stall_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ret_valid_i && mem_stalled) |=> !warp_ready[$past(mem_ret_wid_i)]);

  // R9
  retire_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_i |=> !warp_resident[$past(retire_wid_i)]);

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot_chk
    // R3
    grant_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_valid_o[s] |-> (warp_ready[gw[s]] && (int'(gw[s]) % int'(NUM_SLOTS)) == s));

    // R5
    idle_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grant_valid_o[s] |-> !slot_any[s]);

    // R6
    stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_valid_o[s] && stall_i[s]) |=> !warp_ready[$past(gw[s])]);

    for (genvar t = s + 1; t < int'(NUM_SLOTS); t++) begin : g_pair
      // R11
      distinct_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_valid_o[s] && grant_valid_o[t]) |-> gw[s] != gw[t]);
    end
  end
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS),
  .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_wid_i    (alloc_wid_i),
  .retire_valid_i (retire_valid_i),
  .retire_wid_i   (retire_wid_i),
  .stall_i        (stall_i),
  .mem_ret_valid_i(mem_ret_valid_i),
  .mem_ret_wid_i  (mem_ret_wid_i),
  .grant_valid_o  (grant_valid_o),
  .grant_wid_o    (grant_wid_o),
  .warp_ready     (warp_ready),
  .warp_resident  (warp_resident)
);

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;
  localparam int NW  = 64;
  localparam int NS  = 4;
  localparam int WW  = 6;
  localparam int PER = NW / NS;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            alloc_valid_i = 1'b0;
  logic [WW-1:0]   alloc_wid_i = '0;
  logic            retire_valid_i = 1'b0;
  logic [WW-1:0]   retire_wid_i = '0;
  logic [NS-1:0]   stall_i = '0;
  logic            mem_ret_valid_i = 1'b0;
  logic [WW-1:0]   mem_ret_wid_i = '0;
  logic [NS-1:0]   grant_valid_o;
  logic [NS*WW-1:0] grant_wid_o;

  always #5 clk_i = ~clk_i;

  warp_issue_sched u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_wid_i(alloc_wid_i),
    .retire_valid_i(retire_valid_i), .retire_wid_i(retire_wid_i),
    .stall_i(stall_i),
    .mem_ret_valid_i(mem_ret_valid_i), .mem_ret_wid_i(mem_ret_wid_i),
    .grant_valid_o(grant_valid_o), .grant_wid_o(grant_wid_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R1 reset";

  bit m_res [NW];
  bit m_wait[NW];
  int m_last[NS];
  bit exp_v [NS];
  int exp_w [NS];

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic predict();
    for (int s = 0; s < NS; s++) begin
      exp_v[s] = 0;
      exp_w[s] = 0;
      for (int i = 1; i <= PER; i++) begin
        int l = (m_last[s] + i) % PER;
        int w = l * NS + s;
        if (!exp_v[s] && m_res[w] && !m_wait[w]) begin
          exp_v[s] = 1;
          exp_w[s] = w;
        end
      end
    end
  endtask

  task automatic compare();
    for (int s = 0; s < NS; s++) begin
      int gw = int'(grant_wid_o[s*WW +: WW]);
      chk(grant_valid_o[s] == exp_v[s], {phase, " grant valid"}, int'(grant_valid_o[s]), int'(exp_v[s]));
      if (exp_v[s] && grant_valid_o[s])
        chk(gw == exp_w[s], {phase, " grant id"}, gw, exp_w[s]);
      if (grant_valid_o[s])
        chk(gw % NS == s, "R3 slot partition", gw % NS, s);
      for (int t = s + 1; t < NS; t++) begin
        if (grant_valid_o[s] && grant_valid_o[t])
          chk(gw != int'(grant_wid_o[t*WW +: WW]), "R11 distinct grants", gw, -1);
      end
    end
  endtask

  task automatic model_update();
    bit nres [NW];
    bit nwait[NW];
    for (int w = 0; w < NW; w++) begin
      nres[w] = m_res[w];
      nwait[w] = m_wait[w];
    end
    if (mem_ret_valid_i) nwait[mem_ret_wid_i] = 0;
    for (int s = 0; s < NS; s++) begin
      if (exp_v[s]) begin
        m_last[s] = exp_w[s] / NS;
        if (stall_i[s]) nwait[exp_w[s]] = 1;
      end
    end
    if (alloc_valid_i && !m_res[alloc_wid_i]) begin
      nres[alloc_wid_i] = 1;
      nwait[alloc_wid_i] = 0;
    end
    if (retire_valid_i) begin
      nres[retire_wid_i] = 0;
      nwait[retire_wid_i] = 0;
    end
    for (int w = 0; w < NW; w++) begin
      m_res[w] = nres[w];
      m_wait[w] = nwait[w];
    end
  endtask

  task automatic tick();
    predict();
    compare();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    alloc_valid_i = 0;
    retire_valid_i = 0;
    stall_i = '0;
    mem_ret_valid_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_0B57;
    for (int w = 0; w < NW; w++) begin m_res[w] = 0; m_wait[w] = 0; end
    for (int s = 0; s < NS; s++) m_last[s] = PER - 1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    // R1: nothing granted after reset
    chk(grant_valid_o == '0, "R1 reset grants", int'(grant_valid_o), 0);
    tick(); tick();

    phase = "R2 allocate";
    for (int w = 0; w < 12; w++) begin
      alloc_valid_i = 1; alloc_wid_i = WW'(w); tick();
    end
    phase = "R4 round robin";
    repeat (20) tick();

    phase = "R6 stall";
    repeat (3) begin stall_i = '1; tick(); end
    phase = "R5 all waiting";
    chk(grant_valid_o == '0, "R5 idle after stalls", int'(grant_valid_o), 0);
    repeat (3) tick();

    phase = "R7 return";
    for (int w = 0; w < 6; w++) begin
      mem_ret_valid_i = 1; mem_ret_wid_i = WW'(w); tick();
    end
    repeat (8) tick();

    phase = "R8 stall with return";
    predict();
    if (exp_v[0]) begin
      stall_i[0] = 1; mem_ret_valid_i = 1; mem_ret_wid_i = WW'(exp_w[0]);
    end
    chk(exp_v[0], "R8 setup grant on slot 0", int'(exp_v[0]), 1);
    tick();
    repeat (6) tick();

    phase = "R2 allocate of resident waiting warp ignored";
    alloc_valid_i = 1; alloc_wid_i = WW'(7); tick();
    repeat (6) tick();

    phase = "R9 retire then reallocate";
    retire_valid_i = 1; retire_wid_i = WW'(1); tick();
    alloc_valid_i = 1; alloc_wid_i = WW'(1); tick();
    repeat (6) tick();

    phase = "R10 return for free warp";
    mem_ret_valid_i = 1; mem_ret_wid_i = WW'(40); tick();
    repeat (6) tick();

    phase = "R5 empty slot";
    for (int w = 1; w < 12; w += NS) begin
      retire_valid_i = 1; retire_wid_i = WW'(w); tick();
    end
    tick();
    chk(grant_valid_o[1] == 1'b0, "R5 slot 1 idle", int'(grant_valid_o[1]), 0);
    tick();

    phase = "R6 stall on idle slot ignored";
    stall_i = 4'b0010; tick();
    repeat (3) tick();

    phase = "R11 mixed traffic";
    repeat (1500) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      alloc_valid_i   = lfsr[0];
      alloc_wid_i     = lfsr[6:1];
      retire_valid_i  = (lfsr[9:7] == 3'd0);
      retire_wid_i    = lfsr[15:10];
      stall_i         = lfsr[19:16] & {NS{lfsr[20]}};
      mem_ret_valid_i = lfsr[21];
      mem_ret_wid_i   = lfsr[27:22];
      tick();
    end
    finish_run();
  end
endmodule